// File: doc/BRIEF.md
# Serial Synthesiser Word Loader

This block takes programming frames from a three-wire serial bus (a data line, a bit clock and a frame strobe) and turns them into the control words of a frequency synthesiser. The three bus lines are first brought into the system clock domain. While the strobe is high, each rising bit-clock edge shifts one bit, most significant first, into a 24-bit shift register. When the strobe falls, the two bits shifted in last form a destination code. That code copies the frame into one of three holding registers: two frequency words of 22 bits each and one reference word of 16 bits.

The holding registers alone drive the divider and phase-detector fields. A new frame can therefore be shifted in while the loop stays under the control of the words already stored. A select input chooses which frequency word is active, so the idle word can be rewritten and then switched in. No power-down condition gates the storage. No bits are counted: a frame cut short still commits whatever the shift register holds when the strobe falls.

Top module: `synth_prog_regs`

## Requirements
- R1: While `bus_en` is high, each rising edge of `bus_clk` shifts `bus_dat` into the shift register, most significant bit first. Rising edges of `bus_clk` while `bus_en` is low leave the shift register unchanged.
- R2: On a falling edge of `bus_en`, destination code sr[1:0] = 00 (sr[1] is the second-to-last bit shifted, sr[0] the last) copies sr[23:2] into the first frequency word. The other two words keep their values.
- R3: Destination code 10 copies sr[23:2] into the second frequency word. The other two words keep their values.
- R4: Destination code 11 copies sr[17:2] into the reference word. The frequency words keep their values.
- R5: Destination code 01 changes none of the three stored words.
- R6: No stored word changes while a frame is being shifted in. Words change only at the end of a frame.
- R7: `sel_f1` high drives the frequency outputs from the first word and low drives them from the second. Changing the select does not alter either stored word.
- R8: The frequency-word fields are: `m_count` = word[21:7], `a_count` = word[6:3], `pd_sense` = word[2], `pd_gain` = word[1:0].
- R9: The reference-word fields are: `ratio_89` = word[15] (1 selects the 8/9 prescaler pair), `r_count` = word[14:2], `pd_ctl` = word[1:0].
- R10: While `ratio_89` is 1, `a_count[3]` reads 0 whatever the stored bit. While `ratio_89` is 0, the stored bit is shown.
- R11: A frame with fewer bits than a full word still commits the current shift-register contents on the falling strobe, including bits left over from earlier frames.
- R12: A synchronous reset clears the shift register and all three stored words, so every output field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk | input | 1 | Serial bit clock, asynchronous |
| bus_dat | input | 1 | Serial data, asynchronous |
| bus_en | input | 1 | Frame strobe, high during a frame, asynchronous |
| sel_f1 | input | 1 | High selects the first frequency word, low the second |
| m_count | output | 15 | Main divider count of the active frequency word |
| a_count | output | 4 | Swallow count of the active frequency word, top bit masked in 8/9 mode |
| pd_sense | output | 1 | Phase-detector sense of the active frequency word |
| pd_gain | output | 2 | Charge-pump gain code of the active frequency word |
| ratio_89 | output | 1 | Prescaler pair select from the reference word |
| r_count | output | 13 | Reference divider count |
| pd_ctl | output | 2 | Phase-detector control bits from the reference word |

## Verification
The bench sends a frame to the unused destination code. A decoder that treated that code as a valid address would overwrite one of the stored words. Bit-clock pulses are sent with the strobe low, followed by a three-bit frame. A design that shifted without the strobe would change the shift register, and a design that counted bits would drop the short frame; both would commit the wrong word. The outputs are checked halfway through a frame, which catches any word that updates before the strobe falls. The second frequency word is written while the first is selected, which exposes a write that follows the select input instead of the destination code. Finally the 8/9 ratio is toggled under a swallow count whose top bit is set, which shows whether the spare bit is masked.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
   // destination code carried in the last two bits of each frame
   typedef enum logic [1:0] {
      DST_F1   = 2'b00,
      DST_NONE = 2'b01,
      DST_F2   = 2'b10,
      DST_REF  = 2'b11
   } dest_e;
endpackage

// File: rtl/serial_capture.sv
module serial_capture #(
   parameter int SR_W        = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bus_clk,
   input  logic            bus_dat,
   input  logic            bus_en,
   output logic [SR_W-1:0] frame,
   output logic            load
);
   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] ck_s, dt_s, en_s;
   logic                   ck_d, en_d;
   logic [SR_W-1:0]        sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         ck_s <= '0;
         dt_s <= '0;
         en_s <= '0;
         ck_d <= 1'b0;
         en_d <= 1'b0;
      end else begin
         ck_s <= {ck_s[SYNC_STAGES-2:0], bus_clk};
         dt_s <= {dt_s[SYNC_STAGES-2:0], bus_dat};
         en_s <= {en_s[SYNC_STAGES-2:0], bus_en};
         ck_d <= ck_s[LAST];
         en_d <= en_s[LAST];
      end
   end

   logic shift_now;
   assign shift_now = ck_s[LAST] & ~ck_d & en_s[LAST];

   always_ff @(posedge clk) begin
      if (rst)            sr <= '0;
      else if (shift_now) sr <= {sr[SR_W-2:0], dt_s[LAST]};
   end

   assign load  = en_d & ~en_s[LAST];
   assign frame = sr;
endmodule

// File: rtl/buffer_bank.sv
module buffer_bank
   import synth_prog_pkg::*;
#(
   parameter int FREQ_W = 22,
   parameter int REF_W  = 16,
   parameter int SR_W   = FREQ_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [SR_W-1:0]   frame,
   output logic [1:0]        dest,
   output logic [FREQ_W-1:0] f1_q,
   output logic [FREQ_W-1:0] f2_q,
   output logic [REF_W-1:0]  ref_q
);
   generate
      if (SR_W != FREQ_W + 2) begin : g_bad_sr
         $error("buffer_bank: SR_W must equal FREQ_W + 2");
      end
      if (REF_W > FREQ_W) begin : g_bad_ref
         $error("buffer_bank: REF_W must not exceed FREQ_W");
      end
   endgenerate

   dest_e dst;
   assign dst  = dest_e'(frame[1:0]);
   assign dest = frame[1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         f1_q  <= '0;
         f2_q  <= '0;
         ref_q <= '0;
      end else if (load) begin
         unique case (dst)
            DST_F1:   f1_q  <= frame[SR_W-1:2];
            DST_F2:   f2_q  <= frame[SR_W-1:2];
            DST_REF:  ref_q <= frame[REF_W+1:2];
            DST_NONE: ;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/field_decode.sv
module field_decode #(
   parameter int M_W        = 15,
   parameter int A_W        = 4,
   parameter int R_W        = 13,
   parameter bit MASK_SPARE = 1'b1,
   localparam int FREQ_W    = M_W + A_W + 3,
   localparam int REF_W     = R_W + 3
) (
   input  logic              sel_f1,
   input  logic [FREQ_W-1:0] f1_q,
   input  logic [FREQ_W-1:0] f2_q,
   input  logic [REF_W-1:0]  ref_q,
   output logic [M_W-1:0]    m_count,
   output logic [A_W-1:0]    a_count,
   output logic              pd_sense,
   output logic [1:0]        pd_gain,
   output logic              ratio_89,
   output logic [R_W-1:0]    r_count,
   output logic [1:0]        pd_ctl
);
   generate
      if (A_W < 2) begin : g_bad_a
         $error("field_decode: A_W must be at least 2");
      end
   endgenerate

   logic [FREQ_W-1:0] act;
   logic [A_W-1:0]    a_raw;

   assign act      = sel_f1 ? f1_q : f2_q;
   assign m_count  = act[FREQ_W-1 -: M_W];
   assign a_raw    = act[3 +: A_W];
   assign pd_sense = act[2];
   assign pd_gain  = act[1:0];

   assign ratio_89 = ref_q[REF_W-1];
   assign r_count  = ref_q[2 +: R_W];
   assign pd_ctl   = ref_q[1:0];

   generate
      if (MASK_SPARE) begin : g_mask
         assign a_count = ratio_89 ? {1'b0, a_raw[A_W-2:0]} : a_raw;
      end else begin : g_pass
         assign a_count = a_raw;
      end
   endgenerate
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs #(
   parameter int M_W         = 15,
   parameter int A_W         = 4,
   parameter int R_W         = 13,
   parameter int SYNC_STAGES = 2,
   parameter bit MASK_SPARE  = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bus_clk,
   input  logic           bus_dat,
   input  logic           bus_en,
   input  logic           sel_f1,
   output logic [M_W-1:0] m_count,
   output logic [A_W-1:0] a_count,
   output logic           pd_sense,
   output logic [1:0]     pd_gain,
   output logic           ratio_89,
   output logic [R_W-1:0] r_count,
   output logic [1:0]     pd_ctl
);
   localparam int FREQ_W = M_W + A_W + 3;
   localparam int REF_W  = R_W + 3;
   localparam int SR_W   = FREQ_W + 2;

   logic [SR_W-1:0]   frame_w;
   logic              load_w;
   logic [1:0]        dest_w;
   logic [FREQ_W-1:0] f1_w, f2_w;
   logic [REF_W-1:0]  ref_w;

   serial_capture #(.SR_W(SR_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst(rst), .bus_clk(bus_clk), .bus_dat(bus_dat),
      .bus_en(bus_en), .frame(frame_w), .load(load_w)
   );

   buffer_bank #(.FREQ_W(FREQ_W), .REF_W(REF_W), .SR_W(SR_W)) u_bank (
      .clk(clk), .rst(rst), .load(load_w), .frame(frame_w),
      .dest(dest_w), .f1_q(f1_w), .f2_q(f2_w), .ref_q(ref_w)
   );

   field_decode #(.M_W(M_W), .A_W(A_W), .R_W(R_W), .MASK_SPARE(MASK_SPARE)) u_dec (
      .sel_f1(sel_f1), .f1_q(f1_w), .f2_q(f2_w), .ref_q(ref_w),
      .m_count(m_count), .a_count(a_count), .pd_sense(pd_sense),
      .pd_gain(pd_gain), .ratio_89(ratio_89), .r_count(r_count),
      .pd_ctl(pd_ctl)
   );
endmodule

// File: rtl/synth_prog_regs_chk.sv
module synth_prog_regs_chk #(
   parameter int FREQ_W = 22,
   parameter int REF_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              load,
   input logic [1:0]        dest,
   input logic [FREQ_W-1:0] f1_q,
   input logic [FREQ_W-1:0] f2_q,
   input logic [REF_W-1:0]  ref_q
);
   // words move only when a frame ends
   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(f1_q) && $stable(f2_q) && $stable(ref_q)));

   // code 01 writes nothing
   assert_no_dest_R5: assert property (@(posedge clk) disable iff (rst)
      (load && dest == 2'b01) |=> ($stable(f1_q) && $stable(f2_q) && $stable(ref_q)));

   // code 00 leaves the other words alone
   assert_f1_only_R2: assert property (@(posedge clk) disable iff (rst)
      (load && dest == 2'b00) |=> ($stable(f2_q) && $stable(ref_q)));

   // at most one word changes per cycle
   assert_one_word_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({f1_q != $past(f1_q), f2_q != $past(f2_q), ref_q != $past(ref_q)}));

   // reset clears all words
   assert_reset_R12: assert property (@(posedge clk)
      rst |=> (f1_q == '0 && f2_q == '0 && ref_q == '0));
endmodule

bind synth_prog_regs synth_prog_regs_chk #(.FREQ_W(FREQ_W), .REF_W(REF_W)) u_chk (
   .clk(clk), .rst(rst), .load(load_w), .dest(dest_w),
   .f1_q(f1_w), .f2_q(f2_w), .ref_q(ref_w)
);

// File: tb/sim_synth_prog_regs.sv
`timescale 1ns/1ps
module sim_synth_prog_regs;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst, bus_clk, bus_dat, bus_en, sel_f1;
   logic [14:0] m_count;
   logic [3:0]  a_count;
   logic        pd_sense, ratio_89;
   logic [1:0]  pd_gain, pd_ctl;
   logic [12:0] r_count;

   synth_prog_regs u0 (
      .clk(clk), .rst(rst), .bus_clk(bus_clk), .bus_dat(bus_dat),
      .bus_en(bus_en), .sel_f1(sel_f1), .m_count(m_count),
      .a_count(a_count), .pd_sense(pd_sense), .pd_gain(pd_gain),
      .ratio_89(ratio_89), .r_count(r_count), .pd_ctl(pd_ctl)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [23:0] msr;
   logic [21:0] mf1, mf2;
   logic [15:0] mref;

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      logic [21:0] fw;
      logic [3:0]  ea;
      @(negedge clk);
      fw = sel_f1 ? mf1 : mf2;
      ea = fw[6:3];
      if (mref[15]) ea[3] = 1'b0;
      chk(req, "m_count",  32'(m_count),  32'(fw[21:7]));
      chk(req, "a_count",  32'(a_count),  32'(ea));
      chk(req, "pd_sense", 32'(pd_sense), 32'(fw[2]));
      chk(req, "pd_gain",  32'(pd_gain),  32'(fw[1:0]));
      chk(req, "ratio_89", 32'(ratio_89), 32'(mref[15]));
      chk(req, "r_count",  32'(r_count),  32'(mref[14:2]));
      chk(req, "pd_ctl",   32'(pd_ctl),   32'(mref[1:0]));
   endtask

   // send the low n bits of v, MSB first; optional check midway
   task automatic send(input logic [23:0] v, input int n, input int mid);
      bus_en = 1'b1;
      wait_clk(4);
      for (int i = n - 1; i >= 0; i--) begin
         bus_dat = v[i];
         wait_clk(3);
         bus_clk = 1'b1;
         wait_clk(3);
         bus_clk = 1'b0;
         msr = {msr[22:0], v[i]};
         if (i == mid) begin
            wait_clk(4);
            check_all("R6");
         end
      end
      wait_clk(3);
      bus_en = 1'b0;
      wait_clk(6);
      case (msr[1:0])
         2'b00:   mf1  = msr[23:2];
         2'b10:   mf2  = msr[23:2];
         2'b11:   mref = msr[17:2];
         default: ;
      endcase
   endtask

   function automatic logic [23:0] ffrm(input logic [14:0] m, input logic [3:0] a,
                                        input logic s, input logic [1:0] g,
                                        input logic [1:0] ad);
      return {m, a, s, g, ad};
   endfunction

   function automatic logic [23:0] rfrm(input logic r89, input logic [12:0] r,
                                        input logic [1:0] pd);
      return {6'b0, r89, r, pd, 2'b11};
   endfunction

   task automatic do_reset;
      rst = 1'b1;
      wait_clk(3);
      rst = 1'b0;
      msr = '0; mf1 = '0; mf2 = '0; mref = '0;
      wait_clk(2);
   endtask

   task automatic t_reset_state;
      check_all("R12 reset state");
   endtask

   task automatic t_load_f1;   // R2 R8
      sel_f1 = 1'b1;
      send(ffrm(15'h5A3C, 4'h9, 1'b1, 2'b10, 2'b00), 24, -1);
      check_all("R2 R8 f1 load");
   endtask

   task automatic t_load_f2;   // R3 R7
      sel_f1 = 1'b1;
      send(ffrm(15'h1234, 4'hE, 1'b0, 2'b01, 2'b10), 24, -1);
      check_all("R3 f2 hidden while f1 selected");
      sel_f1 = 1'b0;
      check_all("R7 f2 selected");
      sel_f1 = 1'b1;
      check_all("R7 f1 back");
   endtask

   task automatic t_load_ref;  // R4 R9 R10
      send(rfrm(1'b1, 13'h1ABC, 2'b01), 18, -1);
      sel_f1 = 1'b0;
      check_all("R4 R9 R10 ref with 8/9");
      chk("R10", "a_count top masked", 32'(a_count[3]), 32'd0);
      send(rfrm(1'b0, 13'h0F0F, 2'b10), 18, -1);
      check_all("R10 ref with 16/17");
      chk("R10", "a_count top shown", 32'(a_count[3]), 32'd1);
   endtask

   task automatic t_unused_code; // R5
      send(ffrm(15'h7FFF, 4'hF, 1'b1, 2'b11, 2'b01), 24, -1);
      sel_f1 = 1'b1;
      check_all("R5 code 01 f1");
      sel_f1 = 1'b0;
      check_all("R5 code 01 f2");
   endtask

   task automatic t_mid_frame;   // R6
      sel_f1 = 1'b1;
      send(ffrm(15'h0421, 4'h3, 1'b0, 2'b11, 2'b00), 24, 12);
      check_all("R6 after frame end");
   endtask

   task automatic t_idle_and_short; // R1 R11
      bus_dat = 1'b1;
      for (int k = 0; k < 4; k++) begin
         wait_clk(3);
         bus_clk = 1'b1;
         wait_clk(3);
         bus_clk = 1'b0;
      end
      wait_clk(6);
      check_all("R1 idle clocks no load");
      sel_f1 = 1'b1;
      send(24'b100, 3, -1);
      check_all("R1 R11 short frame");
   endtask

   task automatic t_reset_again; // R12
      do_reset();
      check_all("R12 reset after use");
   endtask

   initial begin
      rst = 1'b1; bus_clk = 1'b0; bus_dat = 1'b0; bus_en = 1'b0; sel_f1 = 1'b1;
      msr = '0; mf1 = '0; mf2 = '0; mref = '0;
      wait_clk(5);
      rst = 1'b0;
      wait_clk(2);
      t_reset_state();
      t_load_f1();
      t_load_f2();
      t_load_ref();
      t_unused_code();
      t_mid_frame();
      t_idle_and_short();
      t_reset_again();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule